// File: doc/BRIEF.md
# Complementary PWM Dead-Band Generator

This block turns a free-running 16-bit period counter into a pair of complementary drive signals for a half bridge. The counter steps from 1 up to a programmable reload value and then wraps back to 1. A raw PWM level is set high when the count equals the compare value and cleared when it equals the reload value. The primary output follows the raw level and the complement output follows its inverse.

Each change of the raw level starts a dead band. The output that is turning off goes inactive on that same clock edge. The output that is turning on is held inactive for a number of clocks chosen by a 3-bit code: code 0 gives no hold, and code n gives 2^n clocks. So the two outputs are never active together. If the raw level changes again while a dead band is still running, the dead band starts over, and the output that finally turns on is the one that matches the latest raw level. A polarity input sets the active level for both outputs. While enable is low the counter is held at 1, both outputs are inactive, and a stopped flag is raised.

Top module: `pwm_deadband`

## Requirements
- R1: While enabled, the counter starts at 1, adds one each clock, and returns to 1 on the clock after it equals the reload value. The period is therefore reload clocks (reload must be at least 1).
- R2: The raw level goes to 1 on the edge where the count equals the compare value, and goes to 0 on the edge where the count equals the reload value. Reload wins when both match. Outside a dead band the primary is active exactly when raw is 1, and the complement is active exactly when raw is 0.
- R3: Delay code 0 gives a dead band of 0 clocks. Code n (1..7) gives 2^n clocks. The output turning on becomes active on the edge that comes exactly that many edges after the edge where raw changed.
- R4: On the edge where raw changes, the output that was active goes inactive.
- R5: The primary and the complement are never active in the same cycle.
- R6: A raw change during a running dead band restarts the full dead band, and both outputs stay inactive until it ends. The output that then turns on is the one that matches the latest raw level.
- R7: With polarity 1 both outputs are active high, and with polarity 0 both are active low. The polarity input acts on the outputs combinationally.
- R8: While enable is low, the counter is held at 1, raw is 0, and both outputs are inactive on the next edge. After enable returns, counting starts again from 1.
- R9: The stopped output is 1 in every cycle after an edge where enable was low, and 0 after an edge where it was high.
- R10: After reset both outputs are inactive, stopped is 1, and the counter is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the counter when high |
| reloadVal | input | 16 | Last count of the period |
| compareVal | input | 16 | Count at which raw PWM goes high |
| delayCode | input | 3 | Dead-band code, 0 or 2^code clocks |
| polarity | input | 1 | Active level of both outputs (1 = high) |
| outPri | output | 1 | Primary drive output |
| outCmp | output | 1 | Complement drive output |
| stopped | output | 1 | High while the counter is not running |

## Verification
A stale or miscounted dead-band register shows up at the output that is turning on. That output rises too early or too late, and the error can be seen in the very cycle where it should have become active. It is checked against a reference gap of 2^code clocks for every code. A wrong period count or wrong raw level shifts an edge of the output waveform within one period, so comparing both outputs every cycle against an independent model catches it within reload clocks. An overlap fault appears as both outputs active in a single cycle.

// File: rtl/pwmdt_pkg.sv
package pwmdt_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntHold;  // force counter to 1 and clear dead-band timer
    logic cntWrap;  // reload reached, count restarts at 1
    logic dlyLoad;  // raw edge: load dead-band length
    logic dlyTick;  // dead-band timer decrement
  } dpStrobe_t;

  // Status flags from datapath to control
  typedef struct packed {
    logic rldHit;
    logic cmpHit;
    logic dlyZero;
    logic dlyLast;
    logic lenZero;
  } dpFlag_t;

endpackage

// File: rtl/pwmdt_datapath.sv
module pwmdt_datapath
  import pwmdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic [CNT_W-1:0]  compareVal,
  input  logic [CODE_W-1:0] delayCode,
  input  dpStrobe_t         stb,
  output dpFlag_t           flg,
  output logic [CNT_W-1:0]  countVal
);

  // Longest dead band is 2^(2^CODE_W - 1), which needs 2^CODE_W bits
  localparam int DLY_W = 2 ** CODE_W;

  logic [CNT_W-1:0] cntQ;
  logic [DLY_W-1:0] dlyQ;
  logic [DLY_W-1:0] dlyLen;

  always_comb begin
    if (delayCode == '0) dlyLen = '0;
    else                 dlyLen = DLY_W'(1) << delayCode;
  end

  // Period counter, 1..reload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cntQ <= CNT_W'(1);
    else if (stb.cntHold || stb.cntWrap) cntQ <= CNT_W'(1);
    else                                cntQ <= cntQ + CNT_W'(1);
  end

  // Dead-band down counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dlyQ <= '0;
    else if (stb.cntHold)   dlyQ <= '0;
    else if (stb.dlyLoad)   dlyQ <= dlyLen;
    else if (stb.dlyTick)   dlyQ <= dlyQ - DLY_W'(1);
  end

  always_comb begin
    flg.rldHit  = (cntQ == reloadVal);
    flg.cmpHit  = (cntQ == compareVal);
    flg.dlyZero = (dlyQ == '0);
    flg.dlyLast = (dlyQ == DLY_W'(1));
    flg.lenZero = (delayCode == '0);
  end

  assign countVal = cntQ;

endmodule

// File: rtl/pwmdt_control.sv
module pwmdt_control
  import pwmdt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  dpFlag_t   flg,
  output dpStrobe_t stb,
  output logic      priOn,
  output logic      cmpOn,
  output logic      runQ
);

  logic rawQ, rawNext, evt;
  logic priNext, cmpNext;

  always_comb begin
    // Raw PWM level: reload clears, compare sets, reload wins
    rawNext = rawQ;
    if (!enable)         rawNext = 1'b0;
    else if (flg.rldHit) rawNext = 1'b0;
    else if (flg.cmpHit) rawNext = 1'b1;

    evt = enable && (rawNext != rawQ);

    stb.cntHold = !enable;
    stb.cntWrap = flg.rldHit;
    stb.dlyLoad = evt;
    stb.dlyTick = enable && !evt && !flg.dlyZero;

    // Outgoing side drops at once; incoming side waits for the timer
    priNext = 1'b0;
    cmpNext = 1'b0;
    if (enable) begin
      if (evt) begin
        if (flg.lenZero) begin
          priNext = rawNext;
          cmpNext = !rawNext;
        end
      end else if (!flg.dlyZero) begin
        if (flg.dlyLast) begin
          priNext = rawQ;
          cmpNext = !rawQ;
        end
      end else begin
        priNext = rawQ;
        cmpNext = !rawQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ  <= 1'b0;
      priOn <= 1'b0;
      cmpOn <= 1'b0;
      runQ  <= 1'b0;
    end else begin
      rawQ  <= rawNext;
      priOn <= priNext;
      cmpOn <= cmpNext;
      runQ  <= enable;
    end
  end

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import pwmdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic [CNT_W-1:0]  compareVal,
  input  logic [CODE_W-1:0] delayCode,
  input  logic              polarity,
  output logic              outPri,
  output logic              outCmp,
  output logic              stopped
);

  localparam int N_OUT = 2;

  dpStrobe_t        stb;
  dpFlag_t          flg;
  logic [CNT_W-1:0] countVal;
  logic             priOn, cmpOn, runQ;
  logic [N_OUT-1:0] onVec, outVec;

  pwmdt_datapath #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .reloadVal(reloadVal), .compareVal(compareVal),
    .delayCode(delayCode), .stb(stb), .flg(flg), .countVal(countVal)
  );

  pwmdt_control u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .flg(flg), .stb(stb),
    .priOn(priOn), .cmpOn(cmpOn), .runQ(runQ)
  );

  assign onVec = {cmpOn, priOn};

  // Same active level for both drive pins
  for (genvar g = 0; g < N_OUT; g++) begin : g_pol
    assign outVec[g] = polarity ? onVec[g] : !onVec[g];
  end

  assign outPri  = outVec[0];
  assign outCmp  = outVec[1];
  assign stopped = !runQ;

endmodule

// File: rtl/pwm_deadband_chk.sv
module pwm_deadband_chk #(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [CNT_W-1:0]  reloadVal,
  input logic [CODE_W-1:0] delayCode,
  input logic              polarity,
  input logic              outPri,
  input logic              outCmp,
  input logic              stopped,
  input logic [CNT_W-1:0]  countVal
);

  logic priAct, cmpAct;
  assign priAct = (outPri == polarity);
  assign cmpAct = (outCmp == polarity);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(priAct && cmpAct));

  assert_count_nonzero_R1: assert property (@(posedge clk) disable iff (!rstN)
    countVal != '0);

  assert_count_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (enable && countVal == reloadVal) |=> countVal == CNT_W'(1));

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!priAct && !cmpAct && countVal == CNT_W'(1)));

  assert_stopped_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> stopped);

  assert_stopped_clr_R9: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> !stopped);

  assert_gap_before_on_R3: assert property (@(posedge clk) disable iff (!rstN)
    (($rose(priAct) || $rose(cmpAct)) && delayCode != '0 && $stable(delayCode))
      |-> (!$past(priAct) && !$past(cmpAct)));

endmodule

bind pwm_deadband pwm_deadband_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .reloadVal(reloadVal),
  .delayCode(delayCode), .polarity(polarity), .outPri(outPri),
  .outCmp(outCmp), .stopped(stopped), .countVal(countVal)
);

// File: tb/sim_pwm_deadband.sv
module sim_pwm_deadband;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] reloadVal = 16'd10;
  logic [15:0] compareVal = 16'd5;
  logic [2:0]  delayCode = 3'd0;
  logic        polarity = 1'b1;
  logic        outPri, outCmp, stopped;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit checkOn = 0;
  bit measureGap = 0;
  string phaseTag = "R2";

  // Reference model state
  bit mRaw = 0;
  int mCnt = 1;
  int mSince = 1000;
  bit mStop = 1;
  bit prevPri = 0, prevCmp = 0;
  int fallAt = 0;
  bit fallValid = 0;

  always #5 clk = ~clk;

  pwm_deadband u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .reloadVal(reloadVal),
    .compareVal(compareVal), .delayCode(delayCode), .polarity(polarity),
    .outPri(outPri), .outCmp(outCmp), .stopped(stopped)
  );

  function automatic int gapOf(input logic [2:0] code);
    return (code == 3'd0) ? 0 : (1 << code);
  endfunction

  function automatic logic lvl(input bit act, input logic pol);
    return pol ? act : !act;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // Model from the requirements: raw per R2, counter per R1, gap per R3
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN || !enable) begin
      mRaw = 0; mCnt = 1; mSince = 1000;
      mStop = 1;
    end else begin
      bit nr;
      nr = (mCnt == reloadVal) ? 1'b0 : ((mCnt == compareVal) ? 1'b1 : mRaw);
      if (nr != mRaw) mSince = 0;
      else if (mSince < 1000) mSince++;
      mCnt = (mCnt == reloadVal) ? 1 : mCnt + 1;
      mRaw = nr;
      mStop = 0;
    end
  end

  always @(posedge clk) begin
    #3;
    if (checkOn) begin
      int d;
      bit ePri, eCmp, pa, ca;
      string tg;
      d = gapOf(delayCode);
      ePri = !mStop && mRaw && (mSince >= d);
      eCmp = !mStop && !mRaw && (mSince >= d);
      tg = mStop ? "R8" : ((mSince < d) ? "R3" : phaseTag);
      chk(outPri == lvl(ePri, polarity), {tg, " primary"}, outPri, lvl(ePri, polarity));
      chk(outCmp == lvl(eCmp, polarity), {tg, " complement"}, outCmp, lvl(eCmp, polarity));
      chk(stopped == mStop, "R9 stopped", stopped, mStop);
      pa = (outPri == polarity);
      ca = (outCmp == polarity);
      chk(!(pa && ca), "R5 overlap", {pa, ca}, 0);
      if (!mStop && mSince == 0) // R4: outgoing side off on the raw edge
        chk(!(mRaw ? ca : pa), "R4 outgoing", mRaw ? ca : pa, 0);
      if ((prevPri && !pa) || (prevCmp && !ca)) begin
        fallAt = cyc; fallValid = 1;
      end
      if (measureGap && fallValid && ((pa && !prevPri) || (ca && !prevCmp))) begin
        chk(cyc - fallAt == d, "R3 gap", cyc - fallAt, d);
        fallValid = 0;
      end
      if (mStop) fallValid = 0;
      prevPri = pa; prevCmp = ca;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input int r, input int c, input int code, input bit pol);
    @(negedge clk);
    enable = 0;
    cycles(3);
    reloadVal = 16'(r); compareVal = 16'(c);
    delayCode = 3'(code); polarity = pol;
    @(negedge clk);
    enable = 1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    cycles(3);
    // R10: reset state
    chk(outPri == 1'b0 && outCmp == 1'b0, "R10 outputs", {outPri, outCmp}, 0);
    chk(stopped == 1'b1, "R10 stopped", stopped, 1);
    rstN = 1;
    checkOn = 1;
    cycles(4);

    // R3: every delay code with room for the full gap on both halves
    measureGap = 1;
    phaseTag = "R3";
    for (int k = 0; k < 8; k++) begin
      int c;
      c = gapOf(3'(k)) + 6;
      configure(2 * c + 1, c, k, 1'b1);
      cycles(3 * (2 * c + 1));
    end

    // R1/R2: period and duty with no dead band
    phaseTag = "R1";
    configure(12, 4, 0, 1'b1);
    cycles(40);
    phaseTag = "R2";
    configure(9, 9, 0, 1'b1);  // reload wins, raw stays 0
    cycles(30);
    configure(9, 0, 1, 1'b1);  // compare never matches
    cycles(20);

    // R7: active-low drive, plus a live polarity flip
    phaseTag = "R7";
    configure(30, 12, 2, 1'b0);
    cycles(70);
    polarity = 1'b1;
    cycles(40);

    // R6: raw edges closer than the dead band keep restarting it
    measureGap = 0;
    phaseTag = "R6";
    configure(18, 10, 4, 1'b1);
    cycles(60);
    configure(22, 8, 3, 1'b1);
    cycles(60);

    // R8: disable mid-dead-band and restart from count 1
    phaseTag = "R8";
    configure(40, 20, 3, 1'b1);
    cycles(23);
    enable = 0;
    cycles(5);
    enable = 1;
    cycles(60);

    // Constrained random trials
    phaseTag = "R2";
    for (int t = 0; t < 40; t++) begin
      int r, c, code, d;
      code = $urandom % 8;
      d = gapOf(3'(code));
      r = 2 + ($urandom % 200);
      c = $urandom % (r + 2);
      measureGap = (c > d) && (r - c > d);
      configure(r, c, code, 1'($urandom % 2));
      cycles(3 * r + 10);
    end

    measureGap = 0;
    enable = 0;
    cycles(4);
    checkOn = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule